// File: doc/BRIEF.md
# Software Flow-Control Character Filter

This block sits between a UART receiver and its receive FIFO. It watches each received byte for programmable pause and resume codes. When it sees a pause code, it asks the local transmitter to stop. When it sees a resume code, it lets the transmitter continue. Matched control codes are taken out of the byte stream, so only ordinary data reaches the FIFO.

Two matching modes are available:

- **Single mode:** one code byte is enough to act.
- **Paired mode:** two consecutive bytes must match a programmed pair. While the first byte of a pair is pending, it is held back. If the next byte breaks the pair, the held byte is released as data, in its original order.

The halt request reaches the transmitter only at a character boundary, which the transmitter reports through an input. A character already being shifted out therefore always completes.

Top module: `xflow_ctrl`

## Requirements
- R1: During and just after reset, `txHalt` and `fwdValid` are 0.
- R2: While `enable` is 0:
  - every received byte is forwarded unchanged on the next cycle, including bytes equal to the codes;
  - `txHalt` is 0 on the cycle after `enable` is sampled low;
  - the halt request is cleared.
- R3: In single mode (`pairMode`=0):
  - a byte equal to `xoff1` sets the halt request;
  - a byte equal to `xon1` clears it;
  - neither byte is forwarded;
  - when `xon1` equals `xoff1`, the pause action wins.
- R4: In paired mode (`pairMode`=1):
  - `xoff1` followed directly by `xoff2` sets the halt request;
  - `xon1` followed directly by `xon2` clears it;
  - neither byte of a matched pair is forwarded.
- R5: In paired mode, a held first code whose follower does not complete the pair is forwarded on the cycle after the follower arrives. The follower then goes one of two ways:
  - if it is not itself a first code (`xon1`/`xoff1`), it is forwarded one cycle after that;
  - if it is a first code, it is held as the start of a new pair.
- R6: A byte that is not consumed and not held is forwarded on `fwdByte` with `fwdValid` high on the cycle after its `rxValid` cycle. `fwdValid` is never high otherwise, except for the released bytes of R5.
- R7: The registered halt request is updated one cycle after the deciding byte. `txHalt` in the next cycle equals `enable` AND the halt request AND (`txHalt` OR `txBoundary`). So `txHalt` rises only after a cycle with `txBoundary` high, and falls one cycle after the request clears.
- R8: `rxValid` is never high on two consecutive cycles; this is an input constraint that the block relies on.
- R9: A held first code is discarded whenever `enable` is 0 or `pairMode` is 0. A later second code then passes as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Flow-control filtering on |
| pairMode | input | 1 | 1 = two-byte matching, 0 = single-byte matching |
| xon1 | input | DATA_W | First resume code |
| xon2 | input | DATA_W | Second resume code |
| xoff1 | input | DATA_W | First pause code |
| xoff2 | input | DATA_W | Second pause code |
| rxByte | input | DATA_W | Received byte |
| rxValid | input | 1 | `rxByte` valid this cycle |
| txBoundary | input | 1 | Transmitter is between characters |
| txHalt | output | 1 | Transmitter must not start a new character |
| fwdByte | output | DATA_W | Byte toward the receive FIFO |
| fwdValid | output | 1 | `fwdByte` valid this cycle |

## Verification
The hardest case to reach from the ports is a broken pair whose breaking byte is itself the start of a new pair. In that case one cycle must release the old byte and capture the new one, and a later byte must still complete the new pair. Directed sequences such as pause-first, resume-first, resume-second create this case. A long random stream drawn mostly from the four code values, with `enable` and `pairMode` toggling between bytes, reaches it again from many different states. A behavioural queue model checks every cycle, which also covers the R9 discard taken in the middle of a pair.

// File: rtl/xflow_pkg.sv
package xflow_pkg;
  typedef enum logic [1:0] {
    HK_NONE = 2'd0,
    HK_XON  = 2'd1,
    HK_XOFF = 2'd2
  } heldKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic emitCur;   // forward the incoming byte next cycle
    logic emitHeld;  // forward the held first code next cycle
    logic loadHeld;  // capture the incoming byte as a held first code
    logic stashCur;  // park the incoming byte, forward it one cycle later
  } dpCtl_t;
endpackage

// File: rtl/xflow_match.sv
module xflow_match #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                pairMode,
  input  logic [DATA_W-1:0]   xon1,
  input  logic [DATA_W-1:0]   xon2,
  input  logic [DATA_W-1:0]   xoff1,
  input  logic [DATA_W-1:0]   xoff2,
  input  logic [DATA_W-1:0]   rxByte,
  input  logic                rxValid,
  input  logic                txBoundary,
  output xflow_pkg::dpCtl_t   dpCtl,
  output logic                txHalt
);
  import xflow_pkg::*;

  heldKind_e heldKind, kindNext;
  logic haltReq;
  logic setHalt, clrHalt, pairHit;
  logic isOn1, isOn2, isOff1, isOff2;

  assign isOn1  = (rxByte == xon1);
  assign isOn2  = (rxByte == xon2);
  assign isOff1 = (rxByte == xoff1);
  assign isOff2 = (rxByte == xoff2);

  always_comb begin
    dpCtl    = '0;
    kindNext = heldKind;
    setHalt  = 1'b0;
    clrHalt  = 1'b0;
    pairHit  = 1'b0;
    if (rxValid && !enable) begin
      dpCtl.emitCur = 1'b1;
    end else if (rxValid && !pairMode) begin
      if (isOff1)      setHalt = 1'b1;
      else if (isOn1)  clrHalt = 1'b1;
      else             dpCtl.emitCur = 1'b1;
    end else if (rxValid) begin
      pairHit = ((heldKind == HK_XOFF) && isOff2) || ((heldKind == HK_XON) && isOn2);
      if (pairHit) begin
        setHalt  = (heldKind == HK_XOFF);
        clrHalt  = (heldKind == HK_XON);
        kindNext = HK_NONE;
      end else begin
        if (heldKind != HK_NONE) dpCtl.emitHeld = 1'b1;
        if (isOff1) begin
          kindNext       = HK_XOFF;
          dpCtl.loadHeld = 1'b1;
        end else if (isOn1) begin
          kindNext       = HK_XON;
          dpCtl.loadHeld = 1'b1;
        end else begin
          kindNext = HK_NONE;
          if (heldKind != HK_NONE) dpCtl.stashCur = 1'b1;
          else                     dpCtl.emitCur  = 1'b1;
        end
      end
    end
    if (!enable || !pairMode) kindNext = HK_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldKind <= HK_NONE;
      haltReq  <= 1'b0;
      txHalt   <= 1'b0;
    end else begin
      heldKind <= kindNext;
      if (!enable)      haltReq <= 1'b0;
      else if (setHalt) haltReq <= 1'b1;
      else if (clrHalt) haltReq <= 1'b0;
      txHalt <= enable && haltReq && (txHalt || txBoundary);
    end
  end

  // R7
  halt_on_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txHalt) |-> $past(txBoundary));

  // R2
  disable_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !txHalt);

  // R8
  rx_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
endmodule

// File: rtl/xflow_data.sv
module xflow_data #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  xflow_pkg::dpCtl_t   dpCtl,
  input  logic [DATA_W-1:0]   rxByte,
  output logic [DATA_W-1:0]   fwdByte,
  output logic                fwdValid
);
  logic [DATA_W-1:0] heldByte, pendByte;
  logic              pendValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldByte  <= '0;
      pendByte  <= '0;
      pendValid <= 1'b0;
      fwdByte   <= '0;
      fwdValid  <= 1'b0;
    end else begin
      if (dpCtl.loadHeld) heldByte <= rxByte;
      if (dpCtl.stashCur) pendByte <= rxByte;
      fwdValid <= 1'b0;
      if (dpCtl.emitCur) begin
        fwdByte  <= rxByte;
        fwdValid <= 1'b1;
      end else if (dpCtl.emitHeld) begin
        fwdByte  <= heldByte;
        fwdValid <= 1'b1;
      end else if (pendValid) begin
        fwdByte  <= pendByte;
        fwdValid <= 1'b1;
      end
      pendValid <= dpCtl.stashCur;
    end
  end

  // R8
  no_slot_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> !(dpCtl.emitCur || dpCtl.emitHeld));
endmodule

// File: rtl/xflow_ctrl.sv
module xflow_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              pairMode,
  input  logic [DATA_W-1:0] xon1,
  input  logic [DATA_W-1:0] xon2,
  input  logic [DATA_W-1:0] xoff1,
  input  logic [DATA_W-1:0] xoff2,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxValid,
  input  logic              txBoundary,
  output logic              txHalt,
  output logic [DATA_W-1:0] fwdByte,
  output logic              fwdValid
);
  xflow_pkg::dpCtl_t dpCtl;

  xflow_match #(.DATA_W(DATA_W)) match_i (
    .clk(clk), .rstN(rstN), .enable(enable), .pairMode(pairMode),
    .xon1(xon1), .xon2(xon2), .xoff1(xoff1), .xoff2(xoff2),
    .rxByte(rxByte), .rxValid(rxValid), .txBoundary(txBoundary),
    .dpCtl(dpCtl), .txHalt(txHalt)
  );

  xflow_data #(.DATA_W(DATA_W)) data_i (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .rxByte(rxByte),
    .fwdByte(fwdByte), .fwdValid(fwdValid)
  );

  // R3
  single_consume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !pairMode && rxValid && (rxByte == xon1 || rxByte == xoff1)) |=> !fwdValid);

  // R6
  fwd_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> ($past(rxValid) || $past(rxValid, 2)));
endmodule

// File: tb/xflow_ctrl_tb_top.sv
module xflow_ctrl_tb_top;
  localparam int DATA_W = 8;
  localparam logic [7:0] ON1 = 8'h11, ON2 = 8'h12, OFF1 = 8'h13, OFF2 = 8'h14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, pairMode = 1'b0, rxValid = 1'b0, txBoundary = 1'b1;
  logic [7:0] rxByte = '0;
  logic txHalt, fwdValid;
  logic [7:0] fwdByte;

  always #10 clk = ~clk;

  xflow_ctrl #(.DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .pairMode(pairMode),
    .xon1(ON1), .xon2(ON2), .xoff1(OFF1), .xoff2(OFF2),
    .rxByte(rxByte), .rxValid(rxValid), .txBoundary(txBoundary),
    .txHalt(txHalt), .fwdByte(fwdByte), .fwdValid(fwdValid)
  );

  int checks = 0, errors = 0;
  string curReq = "R1";

  // behavioural reference
  logic [7:0] outQ[$];
  logic mReq = 1'b0, mTx = 1'b0, mHeldV = 1'b0, mHeldOff = 1'b0;
  logic [7:0] mHeldB = '0;
  logic expValid = 1'b0;
  logic [7:0] expByte = '0;

  always @(posedge clk) begin
    logic nTx;
    if (!rstN) begin
      outQ.delete();
      mReq = 0; mTx = 0; mHeldV = 0; mHeldOff = 0; expValid = 0;
    end else begin
      nTx = enable && mReq && (mTx || txBoundary);
      if (rxValid) begin
        if (!enable) outQ.push_back(rxByte);
        else if (!pairMode) begin
          if (rxByte == OFF1) mReq = 1;
          else if (rxByte == ON1) mReq = 0;
          else outQ.push_back(rxByte);
        end else if (mHeldV && ((mHeldOff && rxByte == OFF2) || (!mHeldOff && rxByte == ON2))) begin
          mReq = mHeldOff; mHeldV = 0;
        end else begin
          if (mHeldV) outQ.push_back(mHeldB);
          if (rxByte == OFF1) begin mHeldV = 1; mHeldOff = 1; mHeldB = rxByte; end
          else if (rxByte == ON1) begin mHeldV = 1; mHeldOff = 0; mHeldB = rxByte; end
          else begin mHeldV = 0; outQ.push_back(rxByte); end
        end
      end
      if (!enable || !pairMode) mHeldV = 0;
      if (!enable) mReq = 0;
      mTx = nTx;
      expValid = (outQ.size() > 0);
      if (expValid) expByte = outQ.pop_front();
    end
  end

  task automatic compareNow();
    checks++;
    if (fwdValid !== expValid || (expValid && fwdByte !== expByte) || txHalt !== mTx) begin
      errors++;
      $display("FAIL %s actual valid=%0b byte=%h halt=%0b expected valid=%0b byte=%h halt=%0b",
               curReq, fwdValid, fwdByte, txHalt, expValid, expByte, mTx);
    end
  endtask

  task automatic checkVal(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compareNow();
  endtask

  task automatic sendByte(input logic [7:0] b, input int gap);
    rxByte = b; rxValid = 1'b1;
    tick();
    rxValid = 1'b0;
    for (int i = 0; i < gap; i++) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    checkVal("R1", txHalt, 1'b0);
    checkVal("R1", fwdValid, 1'b0);
    rstN = 1'b1;
    tick();
    checkVal("R1", txHalt, 1'b0);

    // R2 disabled passthrough of code bytes
    curReq = "R2";
    sendByte(OFF1, 2); sendByte(OFF2, 2); sendByte(8'h41, 2);
    checkVal("R2", txHalt, 1'b0);

    // R3 single mode
    curReq = "R3";
    enable = 1'b1; pairMode = 1'b0;
    sendByte(8'h20, 2); sendByte(OFF1, 3);
    checkVal("R3", txHalt, 1'b1);
    sendByte(ON1, 3);
    checkVal("R3", txHalt, 1'b0);

    // R4 paired match
    curReq = "R4";
    pairMode = 1'b1;
    sendByte(OFF1, 1); sendByte(OFF2, 3);
    checkVal("R4", txHalt, 1'b1);
    sendByte(ON1, 1); sendByte(ON2, 3);
    checkVal("R4", txHalt, 1'b0);

    // R5 broken pairs, incl. a breaker that starts a new pair
    curReq = "R5";
    sendByte(OFF1, 1); sendByte(8'h55, 3);
    sendByte(OFF1, 1); sendByte(ON1, 2); sendByte(ON2, 3);
    sendByte(ON1, 1); sendByte(OFF1, 1); sendByte(OFF2, 3);
    checkVal("R5", txHalt, 1'b1);
    sendByte(ON1, 1); sendByte(ON2, 3);

    // R7 halt waits for a character boundary
    curReq = "R7";
    txBoundary = 1'b0;
    sendByte(OFF1, 1); sendByte(OFF2, 5);
    checkVal("R7", txHalt, 1'b0);
    txBoundary = 1'b1;
    tick(); tick();
    checkVal("R7", txHalt, 1'b1);
    sendByte(ON1, 1); sendByte(ON2, 3);

    // R9 disabling drops a partial match
    curReq = "R9";
    sendByte(OFF1, 1);
    enable = 1'b0; tick(); enable = 1'b1;
    sendByte(OFF2, 3);
    checkVal("R9", txHalt, 1'b0);
    sendByte(ON1, 1);
    pairMode = 1'b0; tick(); pairMode = 1'b1;
    sendByte(ON2, 3);

    // R6 / R8 random stream, rxValid always spaced
    curReq = "R6";
    for (int n = 0; n < 600; n++) begin
      logic [7:0] b;
      case ($urandom % 6)
        0: b = ON1; 1: b = ON2; 2: b = OFF1; 3: b = OFF2;
        default: b = 8'h20 + 8'($urandom % 64);
      endcase
      txBoundary = 1'($urandom % 2);
      if ($urandom % 25 == 0) enable = ~enable;
      if ($urandom % 25 == 0) pairMode = ~pairMode;
      sendByte(b, 1 + int'($urandom % 3));
    end
    repeat (4) tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule